// File: doc/BRIEF.md
# Priority-Aware Edge Slot Allocator

This block sits inside a latency-tolerant gather or scatter stage. It shares one pool of edge-state slots among the vertices that are in flight at the same time. Each vertex is admitted with an identifier, an ordering rank and the number of edges it still has to process. On every cycle the block may hand out one slot. That slot goes to the vertex with the smallest rank that still has edges left. A single high-degree vertex can therefore take the whole pool, and several small vertices can share it when the most urgent one needs only a few.

Slots are tracked as credits. A grant spends one credit, and each retired edge response returns one. A vertex leaves the block only when every edge has been granted and every granted slot has retired. The block then presents a done handshake that carries the vertex identifier. Admission, grant, retire and done all use valid/ready handshakes.

Top module: `edge_slot_alloc`

## Requirements
- R1: After reset `adm_ready` is 1, `gnt_valid` is 0 and `done_valid` is 0.
- R2: When slots are free, `gnt_valid` is 1 and the grant names the context with the smallest rank among contexts with edges left. A vertex admitted later with a smaller rank wins the next grant. At most one grant is made per cycle.
- R3: When two contexts with edges left have equal rank, the lower context index is granted.
- R4: The pool starts with NUM_SLOTS credits. `gnt_valid` stays 0 while all credits are spent. Each accepted retire returns one credit, usable from the next cycle.
- R5: A single vertex with at least NUM_SLOTS edges receives all NUM_SLOTS slots in consecutive grants.
- R6: When the smallest-rank vertex needs fewer edges than there are free slots, the remaining slots go to the next vertices in rank order, in the same pass.
- R7: A vertex is stored in the lowest free context index. `gnt_ctx` is that index. `gnt_edge` counts 0, 1, 2 and so on for each vertex.
- R8: When a vertex has no edges left and no slots outstanding, `done_valid` rises with `done_vid` equal to its identifier. This also covers a vertex admitted with zero edges. Both signals hold until `done_ready` is 1, and the context is then free.
- R9: `adm_ready` is 0 while all NUM_CTX contexts are occupied.
- R10: A cycle with both an accepted grant and an accepted retire leaves the credit count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adm_valid | input | 1 | New vertex offered |
| adm_ready | output | 1 | A context is free |
| adm_vid | input | VID_W | Vertex identifier |
| adm_rank | input | RANK_W | Ordering rank, smaller is more urgent |
| adm_edges | input | CNT_W | Number of edges to process |
| gnt_valid | output | 1 | A slot grant is offered |
| gnt_ready | input | 1 | Grant accepted |
| gnt_ctx | output | CTX_W | Context index of the granted vertex |
| gnt_edge | output | CNT_W | Edge index within that vertex |
| ret_valid | input | 1 | An edge slot retires |
| ret_ready | output | 1 | Retire accepted (always 1) |
| ret_ctx | input | CTX_W | Context that owned the retiring slot |
| done_valid | output | 1 | A vertex has finished |
| done_ready | input | 1 | Done accepted |
| done_vid | output | VID_W | Identifier of the finished vertex |

## Verification
The grant outputs are computed from registered state. A vertex admitted at one clock edge can therefore be granted just after that edge, and a retire accepted at one edge makes its credit visible just after that edge. The bench drives inputs one nanosecond after the rising edge and samples grant and admission outputs at that same point. This gives each grant check an exact cycle. A done pulse appears one cycle after the edge that retired the last slot. The bench polls for it over a short bounded window and then checks that it is held while `done_ready` is low. The credit effect of a simultaneous grant and retire is observed by counting how many further grants the pool supplies.

// File: rtl/edge_slot_pkg.sv
package edge_slot_pkg;
    localparam int DEF_NUM_CTX   = 4;
    localparam int DEF_NUM_SLOTS = 8;
    localparam int DEF_VID_W     = 8;
    localparam int DEF_RANK_W    = 8;
    localparam int DEF_CNT_W     = 8;
endpackage

// File: rtl/edge_slot_first.sv
module edge_slot_first #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/edge_slot_pick.sv
module edge_slot_pick #(
    parameter int N      = 4,
    parameter int RANK_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             req,
    input  logic [N-1:0][RANK_W-1:0] rank,
    output logic                     found,
    output logic [IDX_W-1:0]         idx
);
    logic [RANK_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || rank[i] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = rank[i];
            end
        end
    end

    always_comb begin
        if (found) begin
            AST_PICK_IS_REQ: assert (req[idx]); // R2
            for (int j = 0; j < N; j++) begin
                if (req[j] && IDX_W'(j) < idx) begin
                    AST_PICK_TIE_LOW: assert (rank[j] > rank[idx]); // R3
                end
                if (req[j]) begin
                    AST_PICK_MIN_RANK: assert (rank[j] >= rank[idx]); // R2
                end
            end
        end
    end
endmodule

// File: rtl/edge_slot_credit.sv
module edge_slot_credit #(
    parameter int NUM_SLOTS = 8,
    localparam int CR_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            give,
    output logic            avail,
    output logic [CR_W-1:0] count
);
    localparam logic [CR_W-1:0] FULL = CR_W'(NUM_SLOTS);
    localparam logic [CR_W-1:0] ONE  = CR_W'(1);

    logic [CR_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (take && !give) begin
            count_d = count_q - ONE;
        end else if (give && !take) begin
            count_d = count_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= FULL;
        end else begin
            count_q <= count_d;
        end
    end

    assign avail = (count_q != '0);
    assign count = count_q;

    AST_CREDIT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> count_q != '0); // R4
    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL); // R4
endmodule

// File: rtl/edge_slot_alloc.sv
module edge_slot_alloc
    import edge_slot_pkg::*;
#(
    parameter int NUM_CTX   = DEF_NUM_CTX,
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int VID_W     = DEF_VID_W,
    parameter int RANK_W    = DEF_RANK_W,
    parameter int CNT_W     = DEF_CNT_W,
    localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adm_valid,
    output logic              adm_ready,
    input  logic [VID_W-1:0]  adm_vid,
    input  logic [RANK_W-1:0] adm_rank,
    input  logic [CNT_W-1:0]  adm_edges,
    output logic              gnt_valid,
    input  logic              gnt_ready,
    output logic [CTX_W-1:0]  gnt_ctx,
    output logic [CNT_W-1:0]  gnt_edge,
    input  logic              ret_valid,
    output logic              ret_ready,
    input  logic [CTX_W-1:0]  ret_ctx,
    output logic              done_valid,
    input  logic              done_ready,
    output logic [VID_W-1:0]  done_vid
);
    localparam int OUT_W = $clog2(NUM_SLOTS + 1);
    localparam int CR_W  = $clog2(NUM_SLOTS + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [OUT_W-1:0] OUT_ONE = OUT_W'(1);

    typedef struct packed {
        logic [NUM_CTX-1:0]             busy;
        logic [NUM_CTX-1:0][VID_W-1:0]  vid;
        logic [NUM_CTX-1:0][RANK_W-1:0] rank;
        logic [NUM_CTX-1:0][CNT_W-1:0]  left;
        logic [NUM_CTX-1:0][CNT_W-1:0]  next_edge;
        logic [NUM_CTX-1:0][OUT_W-1:0]  inflight;
        logic                           done_vld;
        logic [VID_W-1:0]               done_id;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CTX-1:0] want;
    logic [NUM_CTX-1:0] finished;
    logic               free_found, fin_found, pick_found;
    logic [CTX_W-1:0]   free_idx, fin_idx, pick_idx;
    logic               has_credit;
    logic [CR_W-1:0]    credit_cnt;
    logic               gnt_fire, ret_fire, adm_fire, release_ctx;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_flags
        assign want[g]     = st_q.busy[g] && (st_q.left[g] != '0);
        assign finished[g] = st_q.busy[g] && (st_q.left[g] == '0)
                             && (st_q.inflight[g] == '0);
    end

    edge_slot_first #(.N(NUM_CTX)) u_free (
        .vec   (~st_q.busy),
        .found (free_found),
        .idx   (free_idx)
    );

    edge_slot_first #(.N(NUM_CTX)) u_fin (
        .vec   (finished),
        .found (fin_found),
        .idx   (fin_idx)
    );

    edge_slot_pick #(.N(NUM_CTX), .RANK_W(RANK_W)) u_pick (
        .req   (want),
        .rank  (st_q.rank),
        .found (pick_found),
        .idx   (pick_idx)
    );

    edge_slot_credit #(.NUM_SLOTS(NUM_SLOTS)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (gnt_fire),
        .give  (ret_fire),
        .avail (has_credit),
        .count (credit_cnt)
    );

    assign adm_ready   = free_found;
    assign adm_fire    = adm_valid && adm_ready;
    assign gnt_valid   = pick_found && has_credit;
    assign gnt_ctx     = pick_idx;
    assign gnt_edge    = st_q.next_edge[pick_idx];
    assign gnt_fire    = gnt_valid && gnt_ready;
    assign ret_ready   = 1'b1;
    assign ret_fire    = ret_valid;
    assign release_ctx = fin_found && (!st_q.done_vld || done_ready);
    assign done_valid  = st_q.done_vld;
    assign done_vid    = st_q.done_id;

    always_comb begin
        st_d = st_q;
        if (st_q.done_vld && done_ready) begin
            st_d.done_vld = 1'b0;
        end
        if (release_ctx) begin
            st_d.busy[fin_idx] = 1'b0;
            st_d.done_vld      = 1'b1;
            st_d.done_id       = st_q.vid[fin_idx];
        end
        if (adm_fire) begin
            st_d.busy[free_idx]      = 1'b1;
            st_d.vid[free_idx]       = adm_vid;
            st_d.rank[free_idx]      = adm_rank;
            st_d.left[free_idx]      = adm_edges;
            st_d.next_edge[free_idx] = '0;
            st_d.inflight[free_idx]  = '0;
        end
        if (gnt_fire) begin
            st_d.left[pick_idx]      = st_q.left[pick_idx] - CNT_ONE;
            st_d.next_edge[pick_idx] = st_q.next_edge[pick_idx] + CNT_ONE;
            st_d.inflight[pick_idx]  = st_q.inflight[pick_idx] + OUT_ONE;
        end
        if (ret_fire) begin
            st_d.inflight[ret_ctx] = st_d.inflight[ret_ctx] - OUT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ready) |=> (done_valid && $stable(done_vid))); // R8
    AST_ADM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.busy) |-> !adm_ready); // R9
    AST_NO_GRANT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> credit_cnt != '0); // R4
    AST_SWAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_fire && ret_fire) |=> credit_cnt == $past(credit_cnt)); // R10
endmodule

// File: tb/edge_slot_alloc_bench.sv
module edge_slot_alloc_bench;
    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       adm_valid, adm_ready;
    logic [7:0] adm_vid, adm_rank, adm_edges;
    logic       gnt_valid, gnt_ready;
    logic [1:0] gnt_ctx;
    logic [7:0] gnt_edge;
    logic       ret_valid, ret_ready;
    logic [1:0] ret_ctx;
    logic       done_valid, done_ready;
    logic [7:0] done_vid;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;

    localparam int EXP_CTX [8]  = '{1, 1, 1, 0, 0, 2, 2, 2};
    localparam int EXP_EDGE [8] = '{0, 1, 2, 0, 1, 0, 1, 2};

    always #(CLK_NS / 2) clk = ~clk;

    edge_slot_alloc u_edge_slot_alloc (
        .clk(clk), .rst_n(rst_n),
        .adm_valid(adm_valid), .adm_ready(adm_ready), .adm_vid(adm_vid),
        .adm_rank(adm_rank), .adm_edges(adm_edges),
        .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_ctx(gnt_ctx),
        .gnt_edge(gnt_edge),
        .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_ctx(ret_ctx),
        .done_valid(done_valid), .done_ready(done_ready), .done_vid(done_vid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; adm_valid = 0; adm_vid = 0; adm_rank = 0; adm_edges = 0;
        gnt_ready = 0; ret_valid = 0; ret_ctx = 0; done_ready = 1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic admit(input int vid, input int rank, input int edges);
        adm_valid = 1; adm_vid = 8'(vid); adm_rank = 8'(rank); adm_edges = 8'(edges);
        tick();
        adm_valid = 0;
    endtask

    task automatic grab(input string tag, input int ctx, input int edge_i);
        chk({tag, " gnt_valid"}, int'(gnt_valid), 1);
        chk({tag, " gnt_ctx"}, int'(gnt_ctx), ctx);
        chk({tag, " gnt_edge"}, int'(gnt_edge), edge_i);
        gnt_ready = 1;
        tick();
        gnt_ready = 0;
    endtask

    task automatic retire(input int ctx);
        ret_valid = 1; ret_ctx = 2'(ctx);
        tick();
        ret_valid = 0;
    endtask

    task automatic wait_done(input string tag, input int exp_vid);
        bit seen = 0;
        int vid  = -1;
        for (int k = 0; k < 8; k++) begin
            if (done_valid) begin
                seen = 1;
                vid  = int'(done_vid);
                break;
            end
            tick();
        end
        chk({tag, " done seen"}, int'(seen), 1);
        chk({tag, " done_vid"}, vid, exp_vid);
        tick();
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        do_reset();
        // R1 reset state
        chk("R1 adm_ready", int'(adm_ready), 1);
        chk("R1 gnt_valid", int'(gnt_valid), 0);
        chk("R1 done_valid", int'(done_valid), 0);

        // Table walk: R2 rank order, R6 sharing, R7 context and edge numbering
        admit(10, 5, 2);
        admit(11, 2, 3);
        admit(12, 7, 9);
        for (int i = 0; i < 8; i++) begin
            grab($sformatf("R2/R6/R7 table[%0d]", i), EXP_CTX[i], EXP_EDGE[i]);
        end
        chk("R4 pool exhausted", int'(gnt_valid), 0);

        // R4 retires return credits
        retire(1); retire(1); retire(1);
        chk("R4 credit back valid", int'(gnt_valid), 1);
        chk("R4 credit back ctx", int'(gnt_ctx), 2);
        chk("R4 credit back edge", int'(gnt_edge), 3);
        wait_done("R8 vertex 11", 11);

        // R10 simultaneous grant and retire keep credits at 3
        chk("R10 pre edge", int'(gnt_edge), 3);
        ret_valid = 1; ret_ctx = 2'd0; gnt_ready = 1;
        tick();
        ret_valid = 0; gnt_ready = 0;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            if (!gnt_valid) break;
            gnt_ready = 1;
            tick();
            gnt_ready = 0;
            n++;
        end
        chk("R10 grants after swap", n, 3);

        // R8 done held while done_ready low
        done_ready = 0;
        retire(0);
        repeat (3) tick();
        chk("R8 hold valid", int'(done_valid), 1);
        chk("R8 hold vid", int'(done_vid), 10);
        done_ready = 1;
        tick();
        chk("R8 release", int'(done_valid), 0);

        // R2 later lower rank wins, R7 lowest free context
        chk("R7 adm_ready", int'(adm_ready), 1);
        admit(13, 1, 1);
        grab("R2 late low rank", 0, 0);

        // R5 one vertex takes the whole pool
        do_reset();
        admit(20, 9, 20);
        for (int i = 0; i < 8; i++) begin
            grab($sformatf("R5 slot %0d", i), 0, i);
        end
        chk("R5 pool empty", int'(gnt_valid), 0);

        // R3 tie, R9 full stall
        do_reset();
        admit(30, 3, 4);
        admit(31, 3, 4);
        chk("R3 tie ctx", int'(gnt_ctx), 0);
        chk("R3 tie valid", int'(gnt_valid), 1);
        admit(32, 3, 4);
        admit(33, 3, 4);
        chk("R9 full stall", int'(adm_ready), 0);

        // R8 zero-edge vertex
        do_reset();
        admit(40, 0, 0);
        chk("R8 zero edges no grant", int'(gnt_valid), 0);
        wait_done("R8 zero edges", 40);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule